// File: doc/BRIEF.md
# Dual-Width Instruction Prefetch Refill

This block is the front end of an instruction fetch path for a core that runs either 32-bit instructions (word mode) or 16-bit instructions (halfword mode). It keeps a two-entry prefetch buffer and a program counter. When the PC is written, for example by a taken branch, the block aligns the target to the current instruction size. It reads the instruction at the aligned address into the first slot. It then steps the PC by one instruction and reads the next instruction into the second slot.

The block drives a single memory read port that uses a ready handshake. Each refill carries a cycle cost: a fixed overhead of two cycles, plus one nonsequential access cost and one sequential access cost. Both access costs are supplied as inputs, with separate values for 16-bit and 32-bit accesses. The block also presents the address of the instruction being executed. Software sees the PC two instructions ahead of that instruction.

A mode write that requests the mode already held changes nothing. A write that really changes the mode flips the mode and raises a one-cycle resynchronisation pulse. Surrounding logic uses this pulse to re-evaluate its pending events.

Top module: `fetch_refill_unit`

## Requirements
- R1: After reset, `insn_valid` is 0, `mem_req` is 0, `pc` equals the RESET_PC parameter, `half_mode` is 0 (word mode), `resync` is 0 and `refill_cycles` is 0.
- R2: A PC write accepted while idle aligns the target downward. In word mode bits [1:0] are cleared; in halfword mode bit 0 is cleared. The first memory request is issued at the aligned address.
- R3: The refill fills the slots and steps the PC as follows.
  - Slot 0 takes the data read at the aligned address.
  - The PC then advances by the instruction size: 4 in word mode, 2 in halfword mode.
  - Slot 1 takes the data read at the advanced address.
  - At completion the PC equals the aligned target plus one instruction size, modulo 2^32.
- R4: When a refill completes, `refill_cycles` equals 2 + nonsequential cost + sequential cost. Word mode uses the 32-bit cost pair and halfword mode uses the 16-bit cost pair.
- R5: `exec_addr` always equals `pc` minus twice the instruction size (8 in word mode, 4 in halfword mode), modulo 2^32.
- R6: A mode write whose requested value equals the held mode leaves `half_mode` unchanged and raises no `resync` pulse.
- R7: A mode write with a different value flips `half_mode` on the next clock edge. In that same cycle `resync` is high, for exactly one cycle.
- R8: From an accepted PC write until the second slot is filled, `insn_valid` is 0, and further PC writes and mode writes are ignored. `insn_valid` rises when slot 1 is filled.
- R9: While `mem_req` is high and `mem_ready` is low, the request and `mem_addr` hold steady.
- R10: `mem_half` reports the access width: 1 for a 16-bit access, 0 for a 32-bit access. In halfword mode a slot takes the low 16 bits of `mem_rdata`, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_wr_en | input | 1 | Request to write the mode bit |
| mode_sel | input | 1 | Requested mode: 1 = halfword, 0 = word |
| pc_wr_en | input | 1 | Request to write the PC |
| pc_wr_data | input | 32 | PC write target |
| cost_nseq_w | input | 4 | Nonsequential cost of a 32-bit access |
| cost_seq_w | input | 4 | Sequential cost of a 32-bit access |
| cost_nseq_h | input | 4 | Nonsequential cost of a 16-bit access |
| cost_seq_h | input | 4 | Sequential cost of a 16-bit access |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_half | output | 1 | Access is 16 bits wide |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Read data valid, request accepted |
| slot0 | output | 32 | First prefetch slot |
| slot1 | output | 32 | Second prefetch slot |
| insn_valid | output | 1 | Both slots hold fresh instructions |
| pc | output | 32 | Software-visible PC |
| exec_addr | output | 32 | Address of the executing instruction |
| half_mode | output | 1 | Current mode |
| resync | output | 1 | One-cycle pulse after a real mode change |
| refill_cycles | output | 6 | Cost of the last completed refill |

## Verification
The bench builds the block with RESET_PC set to 0x100. Because this is not zero, the reset check can tell a PC that was loaded at reset from one that was merely cleared. The bench keeps the default 4-bit cost inputs and 6-bit cycle count, so all-ones cost pairs reach the largest total of 32, which must not wrap. A target near the top of the 32-bit space makes the second fetch address wrap through zero. A memory that withholds ready for several cycles exercises the hold behaviour of the request.

// File: rtl/fru_pkg.sv
package fru_pkg;
  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_FIRST  = 2'd1,
    FS_SECOND = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/fru_rst_sync.sv
module fru_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/fru_mode_reg.sv
module fru_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic sel,
  output logic half_q,
  output logic resync_q
);
  logic change;
  logic half_d;

  always_comb begin
    change = wr_en && (sel != half_q);
    half_d = change ? sel : half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= 1'b0;
      resync_q <= 1'b0;
    end else begin
      half_q   <= half_d;
      resync_q <= change;
    end
  end
endmodule

// File: rtl/fru_refill_ctrl.sv
module fru_refill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int COST_W = 4,
  parameter int CYC_W  = 6,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half,
  input  logic              pc_wr_en,
  input  logic [ADDR_W-1:0] pc_wr_data,
  input  logic [COST_W-1:0] cost_nseq_w,
  input  logic [COST_W-1:0] cost_seq_w,
  input  logic [COST_W-1:0] cost_nseq_h,
  input  logic [COST_W-1:0] cost_seq_h,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] slot0,
  output logic [DATA_W-1:0] slot1,
  output logic              insn_valid,
  output logic [ADDR_W-1:0] pc_q,
  output logic [CYC_W-1:0]  refill_cycles,
  output logic              busy
);
  import fru_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STEP_H = ADDR_W'(2);
  localparam logic [CYC_W-1:0]  FIXED  = CYC_W'(2);

  fetch_st_e         st_q, st_d;
  logic [ADDR_W-1:0] pc_d, aligned, step;
  logic [DATA_W-1:0] slot0_d, slot1_d, fetched;
  logic              valid_d;
  logic [CYC_W-1:0]  pend_q, pend_d, cyc_d, cost_now;
  logic              accept;

  always_comb begin
    step     = half ? STEP_H : STEP_W;
    aligned  = half ? {pc_wr_data[ADDR_W-1:1], 1'b0}
                    : {pc_wr_data[ADDR_W-1:2], 2'b00};
    cost_now = half ? (FIXED + CYC_W'(cost_nseq_h) + CYC_W'(cost_seq_h))
                    : (FIXED + CYC_W'(cost_nseq_w) + CYC_W'(cost_seq_w));
    fetched  = half ? {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]} : mem_rdata;
    accept   = mem_req && mem_ready;
  end

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    slot0_d = slot0;
    slot1_d = slot1;
    valid_d = insn_valid;
    pend_d  = pend_q;
    cyc_d   = refill_cycles;
    unique case (st_q)
      FS_IDLE: begin
        if (pc_wr_en) begin
          pc_d    = aligned;
          pend_d  = cost_now;
          valid_d = 1'b0;
          st_d    = FS_FIRST;
        end
      end
      FS_FIRST: begin
        if (accept) begin
          slot0_d = fetched;
          pc_d    = pc_q + step;
          st_d    = FS_SECOND;
        end
      end
      FS_SECOND: begin
        if (accept) begin
          slot1_d = fetched;
          valid_d = 1'b1;
          cyc_d   = pend_q;
          st_d    = FS_IDLE;
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= FS_IDLE;
      pc_q          <= RESET_PC;
      slot0         <= '0;
      slot1         <= '0;
      insn_valid    <= 1'b0;
      pend_q        <= '0;
      refill_cycles <= '0;
    end else begin
      st_q          <= st_d;
      pc_q          <= pc_d;
      slot0         <= slot0_d;
      slot1         <= slot1_d;
      insn_valid    <= valid_d;
      pend_q        <= pend_d;
      refill_cycles <= cyc_d;
    end
  end

  assign busy     = (st_q != FS_IDLE);
  assign mem_req  = busy;
  assign mem_addr = pc_q;
endmodule

// File: rtl/fetch_refill_unit.sv
module fetch_refill_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int COST_W = 4,
  parameter int CYC_W  = 6,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_en,
  input  logic              mode_sel,
  input  logic              pc_wr_en,
  input  logic [ADDR_W-1:0] pc_wr_data,
  input  logic [COST_W-1:0] cost_nseq_w,
  input  logic [COST_W-1:0] cost_seq_w,
  input  logic [COST_W-1:0] cost_nseq_h,
  input  logic [COST_W-1:0] cost_seq_h,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_half,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [DATA_W-1:0] slot0,
  output logic [DATA_W-1:0] slot1,
  output logic              insn_valid,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] exec_addr,
  output logic              half_mode,
  output logic              resync,
  output logic [CYC_W-1:0]  refill_cycles
);
  localparam logic [ADDR_W-1:0] BACK_W = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] BACK_H = ADDR_W'(4);

  logic srst_n;
  logic busy;

  fru_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fru_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (mode_wr_en && !busy),
    .sel      (mode_sel),
    .half_q   (half_mode),
    .resync_q (resync)
  );

  fru_refill_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .COST_W   (COST_W),
    .CYC_W    (CYC_W),
    .RESET_PC (RESET_PC)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (srst_n),
    .half          (half_mode),
    .pc_wr_en      (pc_wr_en),
    .pc_wr_data    (pc_wr_data),
    .cost_nseq_w   (cost_nseq_w),
    .cost_seq_w    (cost_seq_w),
    .cost_nseq_h   (cost_nseq_h),
    .cost_seq_h    (cost_seq_h),
    .mem_ready     (mem_ready),
    .mem_rdata     (mem_rdata),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .slot0         (slot0),
    .slot1         (slot1),
    .insn_valid    (insn_valid),
    .pc_q          (pc),
    .refill_cycles (refill_cycles),
    .busy          (busy)
  );

  assign mem_half  = half_mode;
  assign exec_addr = pc - (half_mode ? BACK_H : BACK_W);
endmodule

// File: rtl/fru_checker.sv
module fru_checker #(
  parameter int ADDR_W = 32,
  parameter int CYC_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_half,
  input logic              insn_valid,
  input logic [CYC_W-1:0]  refill_cycles,
  input logic              half_mode,
  input logic              resync
);
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  a_r8_no_valid_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !insn_valid);

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_half) |-> (mem_addr[1:0] == 2'b00));

  a_r2_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_half) |-> (mem_addr[0] == 1'b0));

  a_r7_resync_flips: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> (half_mode != $past(half_mode)));

  a_r6_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !resync |-> $stable(half_mode));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);

  a_r4_min_cost: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(insn_valid) |-> (refill_cycles >= CYC_W'(2)));
endmodule

bind fetch_refill_unit fru_checker #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req       (mem_req),
  .mem_ready     (mem_ready),
  .mem_addr      (mem_addr),
  .mem_half      (mem_half),
  .insn_valid    (insn_valid),
  .refill_cycles (refill_cycles),
  .half_mode     (half_mode),
  .resync        (resync)
);

// File: tb/sim_fetch_refill_unit.sv
`timescale 1ns/1ps
module sim_fetch_refill_unit;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr_en = 1'b0, mode_sel = 1'b0;
  logic        pc_wr_en = 1'b0;
  logic [31:0] pc_wr_data = '0;
  logic [3:0]  c_nw = '0, c_sw = '0, c_nh = '0, c_sh = '0;
  logic        mem_req, mem_half, insn_valid, half_mode, resync;
  logic [31:0] mem_addr, mem_rdata, slot0, slot1, pc, exec_addr;
  logic        mem_ready = 1'b1;
  logic [5:0]  refill_cycles;

  int checks = 0, errors = 0;
  logic cur_half = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  assign mem_rdata = {~mem_addr[15:0], mem_addr[15:0] ^ 16'h5A5A};

  fetch_refill_unit #(.RESET_PC(RST_PC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_sel(mode_sel),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
    .cost_nseq_w(c_nw), .cost_seq_w(c_sw), .cost_nseq_h(c_nh), .cost_seq_h(c_sh),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_half(mem_half),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .slot0(slot0), .slot1(slot1), .insn_valid(insn_valid), .pc(pc),
    .exec_addr(exec_addr), .half_mode(half_mode), .resync(resync),
    .refill_cycles(refill_cycles)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_model(input logic [31:0] a, input logic h);
    logic [31:0] w = {~a[15:0], a[15:0] ^ 16'h5A5A};
    return h ? {16'h0000, w[15:0]} : w;
  endfunction

  function automatic logic [31:0] align_of(input logic [31:0] t, input logic h);
    return h ? {t[31:1], 1'b0} : {t[31:2], 2'b00};
  endfunction

  task automatic set_mode(input logic m);
    logic expect_pulse = (m != cur_half);
    @(negedge clk); mode_wr_en = 1'b1; mode_sel = m;
    @(negedge clk); mode_wr_en = 1'b0;
    check(expect_pulse ? "R7 resync" : "R6 resync", {31'b0, resync}, {31'b0, expect_pulse});
    check(expect_pulse ? "R7 mode" : "R6 mode", {31'b0, half_mode}, {31'b0, m});
    @(negedge clk);
    check("R7 pulse width", {31'b0, resync}, 32'd0);
    cur_half = m;
  endtask

  task automatic refill(input logic [31:0] tgt);
    logic [31:0] al = align_of(tgt, cur_half);
    logic [31:0] sz = cur_half ? 32'd2 : 32'd4;
    @(negedge clk); pc_wr_en = 1'b1; pc_wr_data = tgt;
    @(negedge clk); pc_wr_en = 1'b0;
    check("R2 first addr", mem_addr, al);
    check("R8 valid low", {31'b0, insn_valid}, 32'd0);
    check("R10 width", {31'b0, mem_half}, {31'b0, cur_half});
    @(negedge clk);
    check("R3 second addr", mem_addr, al + sz);
    @(negedge clk);
    check("R8 valid high", {31'b0, insn_valid}, 32'd1);
    check("R3 slot0", slot0, mem_model(al, cur_half));
    check("R3 slot1", slot1, mem_model(al + sz, cur_half));
    check("R3 pc", pc, al + sz);
    check("R5 exec", exec_addr, al + sz - 2 * sz);
  endtask

  // {half, target, ns_w, s_w, ns_h, s_h}
  localparam logic [48:0] VEC [6] = '{
    {1'b0, 32'h0000_1003, 4'd1,  4'd1,  4'd0,  4'd0},
    {1'b1, 32'h0000_2007, 4'd0,  4'd0,  4'd3,  4'd1},
    {1'b1, 32'h0000_2FFF, 4'd2,  4'd2,  4'd15, 4'd15},
    {1'b0, 32'hFFFF_FFFE, 4'd15, 4'd15, 4'd1,  4'd1},
    {1'b0, 32'h0000_0004, 4'd0,  4'd0,  4'd9,  4'd9},
    {1'b1, 32'h0000_0001, 4'd5,  4'd7,  4'd0,  4'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'b0, insn_valid}, 32'd0);
    check("R1 req", {31'b0, mem_req}, 32'd0);
    check("R1 pc", pc, RST_PC);
    check("R1 mode", {31'b0, half_mode}, 32'd0);
    check("R1 resync", {31'b0, resync}, 32'd0);
    check("R1 cycles", {26'b0, refill_cycles}, 32'd0);
    check("R5 exec at reset", exec_addr, RST_PC - 32'd8);

    for (int i = 0; i < 6; i++) begin
      logic [48:0] v = VEC[i];
      logic [5:0] exp_cyc;
      c_nw = v[15:12]; c_sw = v[11:8]; c_nh = v[7:4]; c_sh = v[3:0];
      set_mode(v[48]);
      refill(v[47:16]);
      exp_cyc = v[48] ? (6'd2 + 6'(v[7:4]) + 6'(v[3:0]))
                      : (6'd2 + 6'(v[15:12]) + 6'(v[11:8]));
      check("R4 cycles", {26'b0, refill_cycles}, {26'b0, exp_cyc});
    end

    // R6: same-mode write in halfword mode, then word
    set_mode(1'b1);
    set_mode(1'b1);
    set_mode(1'b0);
    set_mode(1'b0);

    // R8: writes during refill ignored
    @(negedge clk); pc_wr_en = 1'b1; pc_wr_data = 32'h0000_4000;
    @(negedge clk); pc_wr_data = 32'h0000_8888; mode_wr_en = 1'b1; mode_sel = 1'b1;
    check("R8 valid low during refill", {31'b0, insn_valid}, 32'd0);
    @(negedge clk); pc_wr_en = 1'b0; mode_wr_en = 1'b0;
    check("R8 second addr kept", mem_addr, 32'h0000_4004);
    check("R8 mode write ignored", {31'b0, half_mode}, 32'd0);
    @(negedge clk);
    check("R8 pc after ignored write", pc, 32'h0000_4004);
    check("R8 no resync", {31'b0, resync}, 32'd0);
    check("R8 slot1", slot1, mem_model(32'h0000_4004, 1'b0));

    // R9: stalled memory
    mem_ready = 1'b0;
    @(negedge clk); pc_wr_en = 1'b1; pc_wr_data = 32'h0000_0A0A;
    @(negedge clk); pc_wr_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R9 req held", {31'b0, mem_req}, 32'd1);
      check("R9 addr held", mem_addr, 32'h0000_0A08);
      @(negedge clk);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    check("R9 second addr", mem_addr, 32'h0000_0A0C);
    @(negedge clk);
    check("R9 valid after stall", {31'b0, insn_valid}, 32'd1);
    check("R9 slot0", slot0, mem_model(32'h0000_0A08, 1'b0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule